// File: doc/BRIEF.md
# Frame-Based Serial Codec Master

This block is the clock-and-frame owner of a synchronous serial link to one or two codec devices that carry audio and telecom samples. It divides the system clock by a programmable ratio to form the serial clock, marks each frame with a one-slot sync pulse, and moves 128-bit frames in both directions. Each frame holds two 64-bit subframes, one for each device, so both devices are served in the same frame.

Software loads one 64-bit transmit holding word per subframe and reads one 64-bit receive holding word per subframe. At each frame boundary the transmit holding words move into the shift path and the bits captured during the frame move into the receive holding words. A single-cycle frame-done strobe tells the host that fresh receive words are ready and that the transmit words may be refilled. How the 8-bit or 16-bit mono or stereo samples are packed inside a 64-bit subframe is left to software. The block only runs as master.

Top module: `codec_frame_master`

## Requirements
- R1: With ratio N on `clk_ratio` (N = 0 counts as 1), the serial clock is high for N system clocks and low for N system clocks, so rising edges are 2N system clocks apart.
- R2: While `enable` is low, `ser_clk`, `ser_sync`, `ser_dout` and `frame_done` are all held low.
- R3: After `enable` goes high, the first serial-clock period is a lead slot with `ser_sync` high. After that, frames of 128 slots follow back to back, and `ser_sync` is high only during slot 127, the slot just before slot 0 of the next frame.
- R4: `ser_dout` sends transmit subframe 0 in slots 0 to 63 and subframe 1 in slots 64 to 127, most significant bit first. Output data and sync change on the same system clock edge as the rising edge of the serial clock.
- R5: `ser_din` is sampled at the serial-clock rising edge that ends each slot. After a full frame, receive word 0 (`rx_sel` = 0) holds slots 0 to 63 with slot 0 in bit 63, and receive word 1 holds slots 64 to 127 in the same way.
- R6: `frame_done` is high for exactly one system clock. It rises on the edge where the serial clock rises to end slot 127, and the receive words are updated on that same edge. It stays low after the lead slot.
- R7: A transmit holding word written while a frame is running does not change that frame. It is first sent in the next frame.
- R8: Clearing `enable` in the middle of a frame drives the serial clock low on the next edge. The receive words keep their earlier contents, no `frame_done` is produced, and the next enable starts again with a lead sync slot.
- R9: After reset both receive words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the link; low stops it and rewinds the frame |
| clk_ratio | input | DIV_W | Half-period of the serial clock in system clocks (0 counts as 1) |
| tx_wr | input | 1 | Write strobe for a transmit holding word |
| tx_sel | input | SEL_W | Subframe that the write goes to |
| tx_wdata | input | SUB_BITS | Transmit holding word data |
| rx_sel | input | SEL_W | Subframe of the receive word to read |
| rx_rdata | output | SUB_BITS | Selected receive holding word |
| frame_done | output | 1 | One-clock strobe after the last bit of a frame |
| ser_clk | output | 1 | Serial clock to the devices |
| ser_sync | output | 1 | Frame sync, high in the slot before slot 0 |
| ser_dout | output | 1 | Serial data to the devices |
| ser_din | input | 1 | Serial data from the devices |

## Verification
The serial clock edge, `ser_sync` and `ser_dout` all come from registers clocked on the same system edge, so all three change together. The bench finds each serial-clock rise by sampling on the falling system-clock edge and reads sync and data in that same sample. `frame_done` and the receive words are one register stage after the sampling decision, which makes them visible in the same falling-edge sample as the rise that closes slot 127. The bench therefore expects the strobe and compares the receive words at exactly that sample, and treats a strobe at any other sample as an error. Serial input is changed one falling edge after a rise, which is at least one system clock before the next rise samples it.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    // Sequencer phase of the frame engine.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

endpackage

// File: rtl/cfm_clkdiv.sv
module cfm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             sclk,
    output logic             rise_evt
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [DIV_W-1:0] eff_ratio;
    logic             wrap;

    always_comb begin
        st_d      = st_q;
        eff_ratio = (ratio == '0) ? DIV_W'(1) : ratio;
        wrap      = (st_q.cnt >= eff_ratio - DIV_W'(1));
        rise_evt  = 1'b0;
        if (!run) begin
            st_d = '0;
        end else if (wrap) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
            rise_evt  = ~st_q.sclk;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.sclk;

endmodule

// File: rtl/cfm_sequencer.sv
module cfm_sequencer
    import cfm_pkg::*;
#(
    parameter int FRAME_BITS = 128,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise_evt,
    output logic load_frame,
    output logic shift_bit,
    output logic sample_bit,
    output logic frame_end,
    output logic sync
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] PREV_POS = POS_W'(FRAME_BITS - 2);

    typedef struct packed {
        phase_e           ph;
        logic [POS_W-1:0] pos;
        logic             sync;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        load_frame = 1'b0;
        shift_bit  = 1'b0;
        sample_bit = 1'b0;
        frame_end  = 1'b0;
        if (!run) begin
            st_d.ph   = PH_IDLE;
            st_d.pos  = '0;
            st_d.sync = 1'b0;
        end else if (rise_evt) begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph   = PH_LEAD;
                    st_d.sync = 1'b1;
                end
                PH_LEAD: begin
                    st_d.ph    = PH_DATA;
                    st_d.pos   = '0;
                    st_d.sync  = 1'b0;
                    load_frame = 1'b1;
                end
                default: begin
                    sample_bit = 1'b1;
                    st_d.sync  = (st_q.pos == PREV_POS);
                    if (st_q.pos == LAST_POS) begin
                        st_d.pos   = '0;
                        load_frame = 1'b1;
                        frame_end  = 1'b1;
                    end else begin
                        st_d.pos  = st_q.pos + POS_W'(1);
                        shift_bit = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, pos: '0, sync: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync = st_q.sync;

endmodule

// File: rtl/cfm_txpath.sv
module cfm_txpath #(
    parameter int SUB_BITS    = 64,
    parameter int NUM_SUB     = 2,
    parameter int SEL_W       = 1,
    localparam int FRAME_BITS = SUB_BITS * NUM_SUB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [SUB_BITS-1:0] wr_data,
    input  logic                load_frame,
    input  logic                shift_bit,
    output logic                dout
);

    typedef struct packed {
        logic [NUM_SUB-1:0][SUB_BITS-1:0] hold;
        logic [FRAME_BITS-1:0]            sh;
        logic                             dout;
    } tx_state_t;

    tx_state_t             st_d, st_q;
    logic [FRAME_BITS-1:0] load_word;

    // Subframe 0 occupies the most significant end so it leaves first.
    for (genvar s = 0; s < NUM_SUB; s++) begin : g_pack
        assign load_word[FRAME_BITS-1-s*SUB_BITS -: SUB_BITS] = st_q.hold[s];
    end

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SUB; s++) begin
            if (wr_en && (int'(wr_sel) == s)) begin
                st_d.hold[s] = wr_data;
            end
        end
        if (!run) begin
            st_d.sh   = '0;
            st_d.dout = 1'b0;
        end else if (load_frame) begin
            st_d.dout = load_word[FRAME_BITS-1];
            st_d.sh   = load_word << 1;
        end else if (shift_bit) begin
            st_d.dout = st_q.sh[FRAME_BITS-1];
            st_d.sh   = st_q.sh << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.dout;

endmodule

// File: rtl/cfm_rxpath.sv
module cfm_rxpath #(
    parameter int SUB_BITS    = 64,
    parameter int NUM_SUB     = 2,
    parameter int SEL_W       = 1,
    localparam int FRAME_BITS = SUB_BITS * NUM_SUB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                din,
    input  logic                sample_bit,
    input  logic                frame_end,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [SUB_BITS-1:0] rd_data,
    output logic                done
);

    typedef struct packed {
        logic [NUM_SUB-1:0][SUB_BITS-1:0] hold;
        logic [FRAME_BITS-1:0]            sh;
        logic                             done;
    } rx_state_t;

    rx_state_t                        st_d, st_q;
    logic [FRAME_BITS-1:0]            cap_word;
    logic [NUM_SUB-1:0][SUB_BITS-1:0] split_word;

    assign cap_word = {st_q.sh[FRAME_BITS-2:0], din};

    // The earliest captured bits form subframe 0.
    for (genvar s = 0; s < NUM_SUB; s++) begin : g_split
        assign split_word[s] = cap_word[FRAME_BITS-1-s*SUB_BITS -: SUB_BITS];
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!run) begin
            st_d.sh = '0;
        end else if (sample_bit) begin
            st_d.sh = cap_word;
            if (frame_end) begin
                st_d.hold = split_word;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NUM_SUB; s++) begin
            if (int'(rd_sel) == s) begin
                rd_data = st_q.hold[s];
            end
        end
    end

    assign done = st_q.done;

endmodule

// File: rtl/codec_frame_master.sv
module codec_frame_master #(
    parameter int SUB_BITS    = 64,
    parameter int NUM_SUB     = 2,
    parameter int DIV_W       = 8,
    localparam int SEL_W      = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1,
    localparam int FRAME_BITS = SUB_BITS * NUM_SUB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [DIV_W-1:0]    clk_ratio,
    input  logic                tx_wr,
    input  logic [SEL_W-1:0]    tx_sel,
    input  logic [SUB_BITS-1:0] tx_wdata,
    input  logic [SEL_W-1:0]    rx_sel,
    output logic [SUB_BITS-1:0] rx_rdata,
    output logic                frame_done,
    output logic                ser_clk,
    output logic                ser_sync,
    output logic                ser_dout,
    input  logic                ser_din
);

    logic rise_evt;
    logic load_frame;
    logic shift_bit;
    logic sample_bit;
    logic frame_end;

    cfm_clkdiv #(
        .DIV_W (DIV_W)
    ) u_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .ratio    (clk_ratio),
        .sclk     (ser_clk),
        .rise_evt (rise_evt)
    );

    cfm_sequencer #(
        .FRAME_BITS (FRAME_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .rise_evt   (rise_evt),
        .load_frame (load_frame),
        .shift_bit  (shift_bit),
        .sample_bit (sample_bit),
        .frame_end  (frame_end),
        .sync       (ser_sync)
    );

    cfm_txpath #(
        .SUB_BITS (SUB_BITS),
        .NUM_SUB  (NUM_SUB),
        .SEL_W    (SEL_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .wr_en      (tx_wr),
        .wr_sel     (tx_sel),
        .wr_data    (tx_wdata),
        .load_frame (load_frame),
        .shift_bit  (shift_bit),
        .dout       (ser_dout)
    );

    cfm_rxpath #(
        .SUB_BITS (SUB_BITS),
        .NUM_SUB  (NUM_SUB),
        .SEL_W    (SEL_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .din        (ser_din),
        .sample_bit (sample_bit),
        .frame_end  (frame_end),
        .rd_sel     (rx_sel),
        .rd_data    (rx_rdata),
        .done       (frame_done)
    );

endmodule

// File: rtl/cfm_checker.sv
module cfm_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [DIV_W-1:0] clk_ratio,
    input logic             ser_clk,
    input logic             ser_sync,
    input logic             ser_dout,
    input logic             frame_done
);

    logic [DIV_W:0] hi_len_q;
    logic [DIV_W:0] eff_ratio;

    assign eff_ratio = (clk_ratio == '0) ? (DIV_W+1)'(1) : {1'b0, clk_ratio};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len_q <= '0;
        end else if (ser_clk) begin
            hi_len_q <= hi_len_q + (DIV_W+1)'(1);
        end else begin
            hi_len_q <= '0;
        end
    end

    // R1
    sclk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ser_clk) && $past(enable) && $stable(clk_ratio)) |-> (hi_len_q == eff_ratio));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ser_clk && !ser_sync && !ser_dout && !frame_done));

    // R4
    sync_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ser_sync) && $past(enable)) |-> $rose(ser_clk));

    // R4
    dout_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ser_dout) && $past(enable)) |-> $rose(ser_clk));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R6
    done_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ($rose(ser_clk) && !ser_sync));

endmodule

bind codec_frame_master cfm_checker #(.DIV_W(DIV_W)) u_cfm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .clk_ratio  (clk_ratio),
    .ser_clk    (ser_clk),
    .ser_sync   (ser_sync),
    .ser_dout   (ser_dout),
    .frame_done (frame_done)
);

// File: tb/codec_frame_master_bench.sv
`timescale 1ns/1ps
module codec_frame_master_bench;

    typedef struct packed {
        logic [7:0]  div;
        logic [63:0] t0;
        logic [63:0] t1;
        logic [63:0] r0;
        logic [63:0] r1;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd1, 64'hA5A5_0F0F_1234_8001, 64'h0123_4567_89AB_CDEF,
                64'hFEDC_BA98_7654_3210, 64'h8000_0000_0000_0001},
        '{8'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000,
                64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
        '{8'd3, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA,
                64'h3C3C_3C3C_3C3C_3C3C, 64'hC3C3_C3C3_C3C3_C3C3},
        '{8'd0, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001,
                64'h0F1E_2D3C_4B5A_6978, 64'h1357_9BDF_0246_8ACE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  clk_ratio = 8'd1;
    logic        tx_wr = 1'b0;
    logic        tx_sel = 1'b0;
    logic [63:0] tx_wdata = '0;
    logic        rx_sel = 1'b0;
    logic [63:0] rx_rdata;
    logic        frame_done;
    logic        ser_clk;
    logic        ser_sync;
    logic        ser_dout;
    logic        ser_din = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0]  m_tx0 = '0;
    logic [63:0]  m_tx1 = '0;
    logic [127:0] din_pat = '0;
    logic [63:0]  m_rx0 = '0;
    logic [63:0]  m_rx1 = '0;

    always #2.5 clk = ~clk;

    codec_frame_master u_codec_frame_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .clk_ratio  (clk_ratio),
        .tx_wr      (tx_wr),
        .tx_sel     (tx_sel),
        .tx_wdata   (tx_wdata),
        .rx_sel     (rx_sel),
        .rx_rdata   (rx_rdata),
        .frame_done (frame_done),
        .ser_clk    (ser_clk),
        .ser_sync   (ser_sync),
        .ser_dout   (ser_dout),
        .ser_din    (ser_din)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr_tx(input logic sel, input logic [63:0] val);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_sel = sel;
        tx_wdata = val;
        @(negedge clk);
        tx_wr = 1'b0;
        if (sel) m_tx1 = val; else m_tx0 = val;
    endtask

    task automatic read_rx(output logic [63:0] w0, output logic [63:0] w1);
        rx_sel = 1'b0;
        #0.5;
        w0 = rx_rdata;
        rx_sel = 1'b1;
        #0.5;
        w1 = rx_rdata;
    endtask

    task automatic stop_link();
        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Acts as the device side: follows serial-clock rises, checks output, drives input.
    task automatic run_frames(input int div, input int frames, input int wr_slot,
                              input logic [63:0] wr_val, input int abort_slot);
        int eff;
        int slot;
        int done_frames;
        int last_rise;
        int cyc;
        int bad_dout;
        int bad_sync;
        int bad_per;
        int bad_fd;
        bit aborted;
        bit exp_fd;
        logic prev;
        logic [127:0] cur;
        logic [63:0] w0;
        logic [63:0] w1;
        eff = (div == 0) ? 1 : div;
        slot = -2;
        done_frames = 0;
        last_rise = -1;
        cyc = 0;
        bad_dout = 0;
        bad_sync = 0;
        bad_per = 0;
        bad_fd = 0;
        aborted = 1'b0;
        prev = 1'b0;
        cur = '0;
        @(negedge clk);
        clk_ratio = 8'(div);
        enable = 1'b1;
        while (done_frames < frames && !aborted) begin
            @(negedge clk);
            cyc++;
            tx_wr = 1'b0;
            exp_fd = 1'b0;
            if (ser_clk && !prev) begin
                if (last_rise >= 0 && (cyc - last_rise) != 2 * eff) bad_per++;
                last_rise = cyc;
                if (slot == -2) begin
                    slot = -1;
                    // R3 R8: every start begins with a lead slot carrying sync
                    chk(ser_sync === 1'b1 && frame_done === 1'b0, "R3 lead sync",
                        {ser_sync, frame_done}, 2'b10);
                    ser_din = 1'b0;
                end else begin
                    if (slot == 127) exp_fd = 1'b1;
                    slot = (slot == 127) ? 0 : slot + 1;
                    if (slot == 0) cur = {m_tx0, m_tx1};
                    if (ser_dout !== cur[127 - slot]) bad_dout++;
                    if (ser_sync !== (slot == 127)) bad_sync++;
                    if (exp_fd) begin
                        done_frames++;
                        m_rx0 = din_pat[127:64];
                        m_rx1 = din_pat[63:0];
                        read_rx(w0, w1);
                        // R5: receive words carry the frame's input bits
                        chk(w0 === m_rx0 && w1 === m_rx1, "R5 rx words", {w0, w1}, din_pat);
                        // R4: data slots follow the holding words MSB first
                        chk(bad_dout == 0, "R4 dout mismatches", 128'(bad_dout), 128'd0);
                        // R3: sync only in slot 127
                        chk(bad_sync == 0, "R3 sync mismatches", 128'(bad_sync), 128'd0);
                        // R1: rise spacing 2N
                        chk(bad_per == 0, "R1 period errors", 128'(bad_per), 128'd0);
                        bad_dout = 0;
                        bad_sync = 0;
                        bad_per = 0;
                    end
                    ser_din = din_pat[127 - slot];
                    if (slot == wr_slot && done_frames == 0) begin
                        tx_wr = 1'b1;
                        tx_sel = 1'b0;
                        tx_wdata = wr_val;
                        m_tx0 = wr_val;
                    end
                    if (slot == abort_slot) begin
                        enable = 1'b0;
                        aborted = 1'b1;
                    end
                end
            end
            if (frame_done !== exp_fd) bad_fd++;
            prev = ser_clk;
        end
        tx_wr = 1'b0;
        // R6: strobe only at the rise closing slot 127
        chk(bad_fd == 0, "R6 frame_done timing errors", 128'(bad_fd), 128'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        summary();
    end

    initial begin
        logic [63:0] w0;
        logic [63:0] w1;
        int hi;
        repeat (3) @(negedge clk);
        // R2 R9: reset state
        chk({ser_clk, ser_sync, ser_dout, frame_done} === 4'b0, "R2 outputs in reset",
            {ser_clk, ser_sync, ser_dout, frame_done}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        read_rx(w0, w1);
        chk(w0 === 64'h0 && w1 === 64'h0, "R9 rx words after reset", {w0, w1}, 128'h0);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ser_clk || ser_sync || ser_dout || frame_done) hi++;
        end
        // R2: idle link stays quiet
        chk(hi == 0, "R2 idle outputs", 128'(hi), 128'd0);

        // Table of vectors
        for (int v = 0; v < 4; v++) begin
            wr_tx(1'b0, VECS[v].t0);
            wr_tx(1'b1, VECS[v].t1);
            din_pat = {VECS[v].r0, VECS[v].r1};
            run_frames(int'(VECS[v].div), 2, -1, 64'h0, -1);
            stop_link();
            // R2: link quiet once disabled
            chk({ser_clk, ser_sync, ser_dout} === 3'b0, "R2 after disable",
                {ser_clk, ser_sync, ser_dout}, 3'b0);
        end

        // R7: mid-frame write only affects the following frame
        wr_tx(1'b0, 64'h1111_2222_3333_4444);
        wr_tx(1'b1, 64'h9999_AAAA_BBBB_CCCC);
        din_pat = {64'hDEAD_BEEF_0000_FFFF, 64'h0F0F_F0F0_1234_5678};
        run_frames(2, 2, 40, 64'h7777_6666_5555_4444, -1);
        stop_link();
        chk(m_tx0 === 64'h7777_6666_5555_4444, "R7 model holds new word", m_tx0,
            64'h7777_6666_5555_4444);

        // R8: abort in the middle of a frame
        din_pat = {64'hCAFE_F00D_1357_2468, 64'h0000_1111_2222_3333};
        run_frames(1, 1, -1, 64'h0, 70);
        @(negedge clk);
        chk(ser_clk === 1'b0, "R8 sclk low after abort", ser_clk, 1'b0);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (ser_clk || frame_done) hi++;
        end
        chk(hi == 0, "R8 no clock or strobe after abort", 128'(hi), 128'd0);
        read_rx(w0, w1);
        chk(w0 === m_rx0 && w1 === m_rx1, "R8 rx words kept", {w0, w1}, {m_rx0, m_rx1});
        // R8: restart opens with a lead sync and runs a full frame
        run_frames(1, 1, -1, 64'h0, -1);
        stop_link();

        summary();
    end

endmodule